// File: doc/BRIEF.md
# High-Speed Chirp Handshake Sequencer

This block is the device-side controller for the high-speed detection handshake when a bus reset arrives while the link is suspended. Its clock comes from the transceiver, and that clock stops during suspend. The block therefore watches the line state without a clock. When reset signaling appears, it releases the suspend request at once, through combinational logic, and leaves every other output untouched until the first clock edge arrives.

From the first edge onward, the block sets the transceiver to raw transmit mode with high-speed selected. It sends a device chirp K for a fixed number of clock cycles. It then filters the line state to find the host's alternating K and J chirps. Once it has enough filtered chirps in the right order, it switches to high-speed termination and reports high-speed mode. If a search window ends first, it restores full-speed settings and reports full-speed mode. Either end state is held until the next reset.

Top module: `chirp_hs_seq`

## Requirements
- R1: During and after a synchronous reset, the block is in the suspended state with suspend_n_o=0, op_mode_o=00 (normal), xcvr_fs_o=1, term_fs_o=1, tx_valid_o=0, hs_mode_o=0 and fs_mode_o=0.
- R2: Line state is encoded as 00=SE0, 01=J, 10=K. While suspended, SE0 on line_state_i raises suspend_n_o with no clock edge required. J or K keeps suspend_n_o low.
- R3: After reset entry, no output other than suspend_n_o changes before the first clock edge, however long the clock stays stopped.
- R4: On the first clock edge that samples SE0 in the suspended state, op_mode_o becomes 10 (bit stuffing and NRZI off), xcvr_fs_o becomes 0 (high-speed), tx_valid_o becomes 1 and tx_data_o becomes all zeros. term_fs_o stays 1.
- R5: tx_valid_o stays high for exactly CHIRP_CYCLES clock cycles (default 66000) and then falls. op_mode_o stays 10 and xcvr_fs_o stays 0 during the search that follows.
- R6: A host K or J chirp counts only on the clock edge that samples the same line state for the FILT_CYCLES-th consecutive time (default 165). Any change restarts the count, so shorter or interrupted runs are rejected.
- R7: Filtered chirps must alternate starting with K. A filtered chirp of the unexpected kind is ignored. High-speed is declared on the edge where the 2*CHIRP_PAIRS-th accepted chirp completes (default 6).
- R8: On high-speed success, hs_mode_o=1, op_mode_o=00, xcvr_fs_o=0 and term_fs_o=0.
- R9: The search is counted from its first clock edge. If no success has occurred by edge SEARCH_TIMEOUT, fs_mode_o=1, op_mode_o=00, xcvr_fs_o=1 and term_fs_o=1. A success on that same edge takes priority.
- R10: Once hs_mode_o or fs_mode_o is set, all outputs hold until reset regardless of line state, and suspend_n_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock; may be stopped while suspended |
| rst | input | 1 | Synchronous active-high reset |
| line_state_i | input | 2 | Bus line state (00 SE0, 01 J, 10 K) |
| suspend_n_o | output | 1 | Active-low suspend request to the transceiver |
| op_mode_o | output | 2 | Operating mode: 00 normal, 01 non-driving, 10 raw |
| xcvr_fs_o | output | 1 | Transceiver select: 1 full-speed, 0 high-speed |
| term_fs_o | output | 1 | Termination select: 1 full-speed, 0 high-speed |
| tx_valid_o | output | 1 | Transmit valid, high during the device chirp |
| tx_data_o | output | DATA_W | Transmit data, zero during the chirp |
| hs_mode_o | output | 1 | Handshake ended in high-speed |
| fs_mode_o | output | 1 | Handshake ended in full-speed |

## Verification
The host-chirp search is tested with several patterns. Clean 200-cycle alternations and runs of exactly the filter length both show the acceptance edge falling where the filter arithmetic predicts. Runs one cycle short show that the threshold is exact. A K run broken by a 3-cycle J glitch shows that an interruption restarts the count. A leading J run shows that an unexpected chirp is ignored, not counted. Runs long enough to finish after the window show that the timeout wins over a late sequence. Each case stops the clock for a different delay, which separates combinational suspend release from clocked behaviour and confirms the exact chirp length.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  typedef enum logic [2:0] {
    ST_SUSP,
    ST_CHIRP,
    ST_SEARCH,
    ST_HS,
    ST_FS
  } seq_state_t;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;
  localparam logic [1:0] LS_SE1 = 2'b11;

  localparam logic [1:0] OPM_NORMAL  = 2'b00;
  localparam logic [1:0] OPM_NODRIVE = 2'b01;
  localparam logic [1:0] OPM_RAW     = 2'b10;
endpackage

// File: rtl/chirp_cycle_timer.sv
module chirp_cycle_timer #(
  parameter int LIMIT = 66000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && (cnt != LAST_VAL)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last_o = (cnt == LAST_VAL);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !last_o) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R5
endmodule

// File: rtl/chirp_line_filter.sv
module chirp_line_filter #(
  parameter int FILT_CYCLES = 165
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] ls_i,
  output logic       hit_o,
  output logic [1:0] hit_ls_o
);
  import chirp_pkg::*;

  localparam int RW = $clog2(FILT_CYCLES + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(FILT_CYCLES);
  localparam logic [RW-1:0] RUN_PRE = RW'(FILT_CYCLES - 1);

  logic [1:0]    prev_ls;
  logic [RW-1:0] run_len;
  logic          same_ls;
  logic          chirp_ls;

  assign same_ls  = (ls_i == prev_ls);
  assign chirp_ls = (ls_i == LS_K) || (ls_i == LS_J);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prev_ls <= LS_SE1;
      run_len <= '0;
    end else if (!same_ls) begin
      prev_ls <= ls_i;
      run_len <= RW'(1);
    end else if (run_len != RUN_MAX) begin
      run_len <= run_len + 1'b1;
    end
  end

  assign hit_o    = en && same_ls && chirp_ls && (run_len == RUN_PRE);
  assign hit_ls_o = ls_i;

  AST_ONE_HIT_PER_RUN: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o); // R6
  AST_HIT_AFTER_STABLE: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (en && $past(en) && ($past(ls_i) == ls_i))); // R6
endmodule

// File: rtl/chirp_hs_seq.sv
module chirp_hs_seq #(
  parameter int CHIRP_CYCLES   = 66000,
  parameter int FILT_CYCLES    = 165,
  parameter int CHIRP_PAIRS    = 3,
  parameter int SEARCH_TIMEOUT = 400000,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        line_state_i,
  output logic              suspend_n_o,
  output logic [1:0]        op_mode_o,
  output logic              xcvr_fs_o,
  output logic              term_fs_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              hs_mode_o,
  output logic              fs_mode_o
);
  import chirp_pkg::*;

  localparam int NCHIRP = 2 * CHIRP_PAIRS;
  localparam int IW     = $clog2(NCHIRP + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NCHIRP - 1);

  seq_state_t    state;
  logic [IW-1:0] chirp_idx;
  logic          chirp_last;
  logic          tmo_last;
  logic          filt_hit;
  logic [1:0]    filt_ls;
  logic [1:0]    want_ls;
  logic          good_hit;
  logic          in_chirp;
  logic          in_search;

  assign in_chirp  = (state == ST_CHIRP);
  assign in_search = (state == ST_SEARCH);
  assign want_ls   = chirp_idx[0] ? LS_J : LS_K;
  assign good_hit  = filt_hit && (filt_ls == want_ls);

  // Suspend is released straight from the line, because no clock runs yet.
  assign suspend_n_o = (state != ST_SUSP) || (line_state_i == LS_SE0);

  chirp_cycle_timer #(.LIMIT(CHIRP_CYCLES)) u_chirp_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (!in_chirp),
    .en     (in_chirp),
    .last_o (chirp_last)
  );

  chirp_cycle_timer #(.LIMIT(SEARCH_TIMEOUT)) u_search_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (!in_search),
    .en     (in_search),
    .last_o (tmo_last)
  );

  chirp_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
    .clk      (clk),
    .rst      (rst),
    .en       (in_search),
    .ls_i     (line_state_i),
    .hit_o    (filt_hit),
    .hit_ls_o (filt_ls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SUSP;
      chirp_idx  <= '0;
      op_mode_o  <= OPM_NORMAL;
      xcvr_fs_o  <= 1'b1;
      term_fs_o  <= 1'b1;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      hs_mode_o  <= 1'b0;
      fs_mode_o  <= 1'b0;
    end else begin
      case (state)
        ST_SUSP: begin
          if (line_state_i == LS_SE0) begin
            state      <= ST_CHIRP;
            op_mode_o  <= OPM_RAW;
            xcvr_fs_o  <= 1'b0;
            tx_valid_o <= 1'b1;
            tx_data_o  <= '0;
          end
        end
        ST_CHIRP: begin
          if (chirp_last) begin
            state      <= ST_SEARCH;
            tx_valid_o <= 1'b0;
            chirp_idx  <= '0;
          end
        end
        ST_SEARCH: begin
          if (good_hit && (chirp_idx == IDX_LAST)) begin
            state     <= ST_HS;
            op_mode_o <= OPM_NORMAL;
            term_fs_o <= 1'b0;
            hs_mode_o <= 1'b1;
          end else if (tmo_last) begin
            state     <= ST_FS;
            op_mode_o <= OPM_NORMAL;
            xcvr_fs_o <= 1'b1;
            term_fs_o <= 1'b1;
            fs_mode_o <= 1'b1;
          end else if (good_hit) begin
            chirp_idx <= chirp_idx + 1'b1;
          end
        end
        default: begin
          state <= state;
        end
      endcase
    end
  end

  AST_CHIRP_FROM_SE0: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid_o) |-> ($past(line_state_i) == LS_SE0)); // R4
  AST_CHIRP_SETTINGS: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> ((tx_data_o == '0) && (op_mode_o == OPM_RAW) && !xcvr_fs_o && term_fs_o)); // R4
  AST_HS_TERM_NEEDS_HS: assert property (@(posedge clk) disable iff (rst)
    !term_fs_o |-> !xcvr_fs_o); // R8
  AST_HS_FROM_FILTER: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode_o) |-> $past(filt_hit)); // R7
  AST_FS_FROM_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_mode_o) |-> $past(tmo_last)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(hs_mode_o && fs_mode_o)); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (hs_mode_o || fs_mode_o) |=> $stable({op_mode_o, xcvr_fs_o, term_fs_o, tx_valid_o, hs_mode_o, fs_mode_o})); // R10
  AST_AWAKE_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (hs_mode_o || fs_mode_o) |-> suspend_n_o); // R10
endmodule

// File: tb/chirp_hs_seq_tb.sv
module chirp_hs_seq_tb;
  import chirp_pkg::*;

  localparam int CHIRP = 2000;
  localparam int FILT  = 165;
  localparam int PAIRS = 3;
  localparam int TMO   = 3000;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          clk_run = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ls = LS_J;
  logic          susp_n, xcvr_fs, term_fs, txv, hs, fs;
  logic [1:0]    opm;
  logic [DW-1:0] txd;

  int n_chk = 0;
  int n_bad = 0;
  int rv[10];
  int rl[10];
  int nr = 0;

  chirp_hs_seq #(
    .CHIRP_CYCLES(CHIRP), .FILT_CYCLES(FILT), .CHIRP_PAIRS(PAIRS),
    .SEARCH_TIMEOUT(TMO), .DATA_W(DW)
  ) u_dut (
    .clk(clk), .rst(rst), .line_state_i(ls), .suspend_n_o(susp_n),
    .op_mode_o(opm), .xcvr_fs_o(xcvr_fs), .term_fs_o(term_fs),
    .tx_valid_o(txv), .tx_data_o(txd), .hs_mode_o(hs), .fs_mode_o(fs)
  );

  // 100 MHz clock that can be held low to model a stopped oscillator.
  initial begin
    forever begin
      #5;
      if (clk_run) clk = ~clk;
      else clk = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add(input logic [1:0] v, input int l);
    rv[nr] = int'(v);
    rl[nr] = l;
    nr++;
  endtask

  function automatic logic [1:0] pat_at(input int k);
    int base = 0;
    for (int i = 0; i < nr; i++) begin
      if (k <= base + rl[i]) return rv[i][1:0];
      base += rl[i];
    end
    return LS_SE0;
  endfunction

  // Expected search edge of the outcome, derived from R6, R7 and R9.
  function automatic int exp_edge(output bit ehs);
    int base = 0;
    int idx = 0;
    int want;
    for (int i = 0; i < nr; i++) begin
      want = (idx % 2 == 0) ? int'(LS_K) : int'(LS_J);
      if (rl[i] >= FILT && rv[i] == want) begin
        if (idx == 2 * PAIRS - 1) begin
          if (base + FILT <= TMO) begin
            ehs = 1'b1;
            return base + FILT;
          end
          break;
        end
        idx++;
      end
      base += rl[i];
    end
    ehs = 1'b0;
    return TMO;
  endfunction

  task automatic run_case(input int dly_ns);
    int  cnt;
    int  ek;
    bit  ehs;
    int  seen_k;
    bit  seen_hs;
    logic [7:0] snap;
    // R1: reset with the clock running
    clk_run = 1'b1;
    rst = 1'b1;
    ls = LS_J;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 suspend_n", int'(susp_n), 0);
    chk("R1 outputs", int'({opm, xcvr_fs, term_fs, txv, hs, fs}), int'({OPM_NORMAL, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}));
    chk("R1 tx_data", int'(txd), 0);
    clk_run = 1'b0;
    #20;
    // R2: K or J while suspended keeps suspend asserted
    ls = LS_K;
    #5;
    chk("R2 K keeps suspend", int'(susp_n), 0);
    ls = LS_J;
    #5;
    chk("R2 J keeps suspend", int'(susp_n), 0);
    ls = LS_SE0;
    #1;
    chk("R2 SE0 releases suspend", int'(susp_n), 1);
    #(dly_ns);
    // R3: nothing clocked has moved while the clock is off
    chk("R3 clock still stopped", int'(clk), 0);
    chk("R3 outputs frozen", int'({opm, xcvr_fs, term_fs, txv, hs, fs}), int'({OPM_NORMAL, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}));
    chk("R3 suspend_n held", int'(susp_n), 1);
    clk_run = 1'b1;
    @(negedge clk);
    // R4: first edge settings
    chk("R4 chirp settings", int'({opm, xcvr_fs, term_fs, txv}), int'({OPM_RAW, 1'b0, 1'b1, 1'b1}));
    chk("R4 tx_data zero", int'(txd), 0);
    // R5: count the chirp length
    cnt = 1;
    while (txv && cnt < CHIRP + 10) begin
      @(negedge clk);
      if (txv) begin
        cnt++;
        if (txd != '0 || opm != OPM_RAW) chk("R4 chirp held", int'({opm, txd}), int'({OPM_RAW, 8'h00}));
      end
    end
    chk("R5 chirp length", cnt, CHIRP);
    chk("R5 search settings", int'({opm, xcvr_fs, term_fs, txv}), int'({OPM_RAW, 1'b0, 1'b1, 1'b0}));
    // R6, R7, R9: drive the host pattern edge by edge
    ek = exp_edge(ehs);
    seen_k = 0;
    seen_hs = 1'b0;
    for (int k = 1; k <= TMO + 4; k++) begin
      ls = pat_at(k);
      @(negedge clk);
      if (seen_k == 0 && (hs || fs)) begin
        seen_k = k;
        seen_hs = hs;
      end
    end
    chk("R6 R7 R9 outcome edge", seen_k, ek);
    chk("R7 R9 outcome kind", int'(seen_hs), int'(ehs));
    if (ehs) chk("R8 hs settings", int'({opm, xcvr_fs, term_fs, hs, fs}), int'({OPM_NORMAL, 1'b0, 1'b0, 1'b1, 1'b0}));
    else     chk("R9 fs settings", int'({opm, xcvr_fs, term_fs, hs, fs}), int'({OPM_NORMAL, 1'b1, 1'b1, 1'b0, 1'b1}));
    // R10: end state holds under further line activity
    snap = {1'b0, opm, xcvr_fs, term_fs, txv, hs, fs};
    ls = LS_K;
    repeat (FILT + 5) @(negedge clk);
    ls = LS_SE0;
    repeat (5) @(negedge clk);
    chk("R10 end state held", int'({1'b0, opm, xcvr_fs, term_fs, txv, hs, fs}), int'(snap));
    chk("R10 suspend_n", int'(susp_n), 1);
  endtask

  initial begin
    // clean alternation
    nr = 0;
    for (int i = 0; i < 6; i++) add((i % 2 == 0) ? LS_K : LS_J, 200);
    run_case(30);
    // runs exactly at the filter length
    nr = 0;
    for (int i = 0; i < 6; i++) add((i % 2 == 0) ? LS_K : LS_J, FILT);
    run_case(500);
    // runs one short of the filter length
    nr = 0;
    for (int i = 0; i < 6; i++) add((i % 2 == 0) ? LS_K : LS_J, FILT - 1);
    run_case(1234);
    // K interrupted by a short J glitch, then good chirps
    nr = 0;
    add(LS_K, 100); add(LS_J, 3); add(LS_K, 100); add(LS_J, 200);
    for (int i = 0; i < 6; i++) add((i % 2 == 0) ? LS_K : LS_J, 200);
    run_case(77);
    // leading J is ignored
    nr = 0;
    add(LS_J, 200);
    for (int i = 0; i < 6; i++) add((i % 2 == 0) ? LS_K : LS_J, 200);
    run_case(4000);
    // sequence that would finish after the window
    nr = 0;
    for (int i = 0; i < 6; i++) add((i % 2 == 0) ? LS_K : LS_J, 600);
    run_case(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(64'd2000000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule